// File: doc/BRIEF.md
# Output Port Packet Spill Watchdog

This block sits beside one output port of a packet switch. It guards against a packet that has been given the port but then stops moving. Without it, such a packet would hold the port, and every packet queued behind it, for good. The block runs a down-counter that only steps on a coarse tick shared by all ports. It loads the counter from a 10-bit reload value when the packet is handed to the port. Each character that leaves on the port loads the counter again, so only a silent gap counts toward a timeout.

When the count runs out, the block raises a one-cycle spill request. The surrounding port logic answers that request by dropping the rest of the packet and closing every destination with an error end-of-packet marker. A sticky status flag records that a timeout happened, and software clears it by writing 1.

The mode bit selects when the watchdog arms. In adaptive routing it arms as soon as this port is assigned. In distribution routing it arms only once the packet holds all of its target ports. A distribution packet that is still waiting for a busy port therefore waits with no time limit.

Top module: `spill_timer`

## Requirements
- R1: After reset, spill_o and timeout_sts_o are 0, and the watchdog is disarmed.
- R2: Arming depends on dist_mode_i. When it is 0, a pulse on assign_i arms the watchdog. When it is 1, only all_assigned_i arms it and assign_i is ignored, so the watchdog is never armed and never times out before that point.
- R3: Arming loads the 10-bit reload_i into the counter. The counter decrements only on a cycle with tick_i high, and only while armed and nonzero. A tick that arrives with the counter at zero is the expiring tick, so spill follows the (reload+1)-th tick after arming.
- R4: While armed, char_sent_i reloads the counter and restarts the full window. If char_sent_i arrives in the same cycle as the expiring tick, the expiry is cancelled.
- R5: eop_sent_i disarms the watchdog. If it arrives in the same cycle as the expiring tick, there is no spill.
- R6: spill_o goes high for exactly one cycle, in the cycle after the clock edge that samples the expiring tick. After that the watchdog is disarmed and stays silent until it is armed again.
- R7: timeout_sts_o is set together with spill_o and holds until sts_clr_i is high. If a set and a clear fall in the same cycle, the set wins.
- R8: While tmr_en_i is 0, the watchdog is disarmed, the counter is held at reload_i and spill_o stays 0. Setting tmr_en_i to 1 again does not re-arm the watchdog; a fresh arming event is needed.
- R9: An arming event that arrives while the watchdog is already armed reloads the counter. In the same cycle it takes priority over eop_sent_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Shared prescaler tick, high for one cycle |
| reload_i | input | 10 | Timeout reload value, in ticks |
| tmr_en_i | input | 1 | Watchdog enable |
| dist_mode_i | input | 1 | 1 = distribution routing, 0 = adaptive routing |
| assign_i | input | 1 | Packet assigned to this port (arms in adaptive mode) |
| all_assigned_i | input | 1 | Packet holds all its ports (arms in distribution mode) |
| char_sent_i | input | 1 | A character was transmitted on the port |
| eop_sent_i | input | 1 | Normal end-of-packet transmitted |
| sts_clr_i | input | 1 | Write-1-to-clear for the timeout flag |
| spill_o | output | 1 | One-cycle spill request |
| timeout_sts_o | output | 1 | Sticky timeout flag |

## Verification
Several properties are checked on every cycle:
- spill_o is a single-cycle pulse that always follows a tick.
- The flag is always set when a spill fires and holds until it is cleared.
- The counter only moves on a load or a decrement, and every load leaves reload_i in the counter.
- A disabled watchdog never spills.
- In distribution mode, the watchdog stays disarmed until all_assigned_i.

Other behaviour can only be shown by the bench scenarios. These cover the exact tick on which expiry lands, restarts from characters and from re-arming, and cancellation by a same-cycle character or end-of-packet. They also cover the indefinite wait in distribution mode and the need to re-arm after the watchdog is enabled again.

// File: rtl/spill_timer_pkg.sv
package spill_timer_pkg;
    localparam int unsigned SPT_RELOAD_W = 10;

    typedef struct packed {
        logic spill;
        logic sts;
    } spt_flags_s;
endpackage

// File: rtl/spt_arm_ctrl.sv
module spt_arm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic dist_mode_i,
    input  logic assign_i,
    input  logic all_assigned_i,
    input  logic eop_i,
    input  logic expire_i,
    output logic armed_o,
    output logic arm_evt_o
);
    logic armed_d, armed_q, arm_evt;

    always_comb begin
        arm_evt = en_i & (dist_mode_i ? all_assigned_i : assign_i);
        armed_d = armed_q;
        if (!en_i)                 armed_d = 1'b0;
        else if (arm_evt)          armed_d = 1'b1;
        else if (eop_i | expire_i) armed_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    assign armed_o   = armed_q;
    assign arm_evt_o = arm_evt;

    AST_DIST_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && dist_mode_i && !all_assigned_i) |=> !armed_q); // R2
    AST_OFF_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !armed_q); // R8
endmodule

// File: rtl/spt_downcount.sv
module spt_downcount #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         dec_i,
    input  logic [W-1:0] reload_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                    cnt_d = reload_i;
        else if (dec_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    AST_CNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !dec_i) |=> $stable(cnt_q)); // R3
    AST_CNT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(reload_i))); // R4
endmodule

// File: rtl/spill_timer.sv
module spill_timer
    import spill_timer_pkg::*;
#(
    parameter int unsigned RELOAD_W = SPT_RELOAD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [RELOAD_W-1:0] reload_i,
    input  logic                tmr_en_i,
    input  logic                dist_mode_i,
    input  logic                assign_i,
    input  logic                all_assigned_i,
    input  logic                char_sent_i,
    input  logic                eop_sent_i,
    input  logic                sts_clr_i,
    output logic                spill_o,
    output logic                timeout_sts_o
);
    logic armed, arm_evt, zero, load, dec, expire;
    spt_flags_s flags_d, flags_q;

    spt_arm_ctrl u_arm (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_i           (tmr_en_i),
        .dist_mode_i    (dist_mode_i),
        .assign_i       (assign_i),
        .all_assigned_i (all_assigned_i),
        .eop_i          (eop_sent_i),
        .expire_i       (expire),
        .armed_o        (armed),
        .arm_evt_o      (arm_evt)
    );

    spt_downcount #(.W(RELOAD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .dec_i    (dec),
        .reload_i (reload_i),
        .zero_o   (zero)
    );

    always_comb begin
        load   = !tmr_en_i | arm_evt | (armed & char_sent_i);
        dec    = armed & tick_i;
        expire = tmr_en_i & armed & tick_i & zero
               & !char_sent_i & !eop_sent_i & !arm_evt;
        flags_d.spill = expire;
        flags_d.sts   = expire | (flags_q.sts & !sts_clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign spill_o       = flags_q.spill;
    assign timeout_sts_o = flags_q.sts;

    AST_SPILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        spill_o |=> !spill_o); // R6
    AST_SPILL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        spill_o |-> timeout_sts_o); // R7
    AST_STS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_sts_o && !sts_clr_i) |=> timeout_sts_o); // R7
    AST_SPILL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spill_o) |-> $past(tick_i)); // R3
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en_i |=> !spill_o); // R8
endmodule

// File: tb/tb_spill_timer.sv
module tb_spill_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 0, tmr_en_i = 0, dist_mode_i = 0, assign_i = 0;
    logic all_assigned_i = 0, char_sent_i = 0, eop_sent_i = 0, sts_clr_i = 0;
    logic [9:0] reload_i = '0;
    logic spill_o, timeout_sts_o;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    int exp_q[$];
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spill_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reload_i(reload_i),
        .tmr_en_i(tmr_en_i), .dist_mode_i(dist_mode_i), .assign_i(assign_i),
        .all_assigned_i(all_assigned_i), .char_sent_i(char_sent_i),
        .eop_sent_i(eop_sent_i), .sts_clr_i(sts_clr_i),
        .spill_o(spill_o), .timeout_sts_o(timeout_sts_o)
    );

    // monitor: every spill pulse must match the next expected cycle
    always @(negedge clk) begin
        if (rst_n && spill_o) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6/R3 unexpected spill at cycle %0d (expected none)", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    n_fail++;
                    $display("FAIL R3 spill at cycle %0d, expected %0d", cyc, e);
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one-cycle drive; pushes expected spill cycle if requested
    task automatic drv(input logic a, input logic al, input logic c, input logic e,
                       input logic t, input logic clr, input bit exp_spill);
        @(negedge clk);
        assign_i = a; all_assigned_i = al; char_sent_i = c;
        eop_sent_i = e; tick_i = t; sts_clr_i = clr;
        if (exp_spill) exp_q.push_back(cyc + 1);
        @(negedge clk);
        assign_i = 0; all_assigned_i = 0; char_sent_i = 0;
        eop_sent_i = 0; tick_i = 0; sts_clr_i = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 1, 0, 0);
    endtask

    task automatic pending_done(input string req);
        check(req, exp_q.size(), 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 spill after reset", spill_o, 0);
        check("R1 status after reset", timeout_sts_o, 0);

        // R3: adaptive, reload 3, spill on 4th tick
        tmr_en_i = 1; reload_i = 10'd3;
        drv(1, 0, 0, 0, 0, 0, 0);
        ticks(3);
        drv(0, 0, 0, 0, 1, 0, 1);
        repeat (2) @(negedge clk);
        pending_done("R3 reload 3 spill");
        check("R7 status set", timeout_sts_o, 1);
        ticks(4);          // R6: disarmed, no further spill
        check("R7 status sticky", timeout_sts_o, 1);
        drv(0, 0, 0, 0, 0, 1, 0);
        check("R7 status cleared", timeout_sts_o, 0);

        // R4: char restarts, same-cycle char cancels expiry
        reload_i = 10'd1;
        drv(1, 0, 0, 0, 0, 0, 0);
        ticks(1);
        drv(0, 0, 1, 0, 1, 0, 0);
        ticks(1);
        drv(0, 0, 0, 0, 1, 0, 1);
        repeat (2) @(negedge clk);
        pending_done("R4 char restart spill");

        // R5: eop disarms
        drv(0, 0, 0, 0, 0, 1, 0);
        reload_i = 10'd2;
        drv(1, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 0, 0, 0, 0);
        drv(0, 0, 0, 1, 0, 0, 0);
        ticks(8);
        check("R5 eop disarm no status", timeout_sts_o, 0);
        reload_i = 10'd0;
        drv(1, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 0, 1, 1, 0, 0);
        ticks(3);
        check("R5 eop with expiring tick", timeout_sts_o, 0);

        // R2: distribution mode waits until all ports held
        dist_mode_i = 1; reload_i = 10'd2;
        drv(1, 0, 0, 0, 0, 0, 0);
        ticks(6);
        check("R2 dist assign ignored", timeout_sts_o, 0);
        drv(0, 1, 0, 0, 0, 0, 0);
        ticks(2);
        drv(0, 0, 0, 0, 1, 0, 1);
        repeat (2) @(negedge clk);
        pending_done("R2 dist spill after all assigned");
        dist_mode_i = 0;
        drv(0, 0, 0, 0, 0, 1, 0);

        // R9: re-arm restarts the window
        reload_i = 10'd2;
        drv(1, 0, 0, 0, 0, 0, 0);
        ticks(2);
        drv(1, 0, 0, 0, 0, 0, 0);
        ticks(2);
        drv(0, 0, 0, 0, 1, 0, 1);
        repeat (2) @(negedge clk);
        pending_done("R9 rearm spill");
        drv(0, 0, 0, 0, 0, 1, 0);

        // R9: arm beats same-cycle eop
        reload_i = 10'd0;
        drv(1, 0, 0, 0, 0, 0, 0);
        drv(1, 0, 0, 1, 0, 0, 0);
        drv(0, 0, 0, 0, 1, 0, 1);
        repeat (2) @(negedge clk);
        pending_done("R9 arm over eop");
        drv(0, 0, 0, 0, 0, 1, 0);

        // R8: disabled
        tmr_en_i = 0; reload_i = 10'd1;
        drv(1, 0, 0, 0, 0, 0, 0);
        ticks(5);
        check("R8 disabled no status", timeout_sts_o, 0);
        tmr_en_i = 1;
        drv(1, 0, 0, 0, 0, 0, 0);
        ticks(1);
        @(negedge clk); tmr_en_i = 0;
        @(negedge clk); tmr_en_i = 1;
        ticks(5);
        check("R8 re-enable needs rearm", timeout_sts_o, 0);
        drv(1, 0, 0, 0, 0, 0, 0);
        ticks(1);
        drv(0, 0, 0, 0, 1, 0, 1);
        repeat (2) @(negedge clk);
        pending_done("R8 rearm after enable");

        // R7: set beats clear in same cycle, R3 reload 0 first tick
        drv(0, 0, 0, 0, 0, 1, 0);
        reload_i = 10'd0;
        drv(1, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 1, 1, 1);
        check("R7 set beats clear", timeout_sts_o, 1);
        repeat (2) @(negedge clk);
        pending_done("R3 reload 0 spill");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule